// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static memory with a pipelined read path and a short internal burst. The default word is 18 bits, split into two 9-bit byte lanes, and the default depth is 256 words. The address, the write data, the chip selects, both load strobes, the step input and all write controls are captured on the rising clock edge. The output enable and the burst-order select act without a clock. A read issued on one edge returns its word after the next edge.

A burst starts when one of two load strobes is asserted. One strobe is meant for a processor and the other for a memory controller. The two low address bits then come from a 2-bit burst counter, which steps in linear or interleaved order whenever the step input is asserted and no strobe is present. A processor-started access always begins as a read, and writes in that burst follow on the later cycles. Three chip selects allow several devices to share a bus. When a load arrives while the device is not selected, its outputs stop driving one edge after that load.

The sequencer holds the cycle type of the access registered in the input stage. It has three states: `ST_IDLE` (deselected), `ST_READ` and `ST_WRITE`. The transitions are:
- *select-read*: any state goes to `ST_READ` on a selected load that is a processor load or that carries no write lanes.
- *select-write*: any state goes to `ST_WRITE` on a selected controller load that carries write lanes.
- *deselect*: any state goes to `ST_IDLE` on a load while unselected.
- *continue*: `ST_READ`/`ST_WRITE` go to `ST_WRITE` or `ST_READ`, following the write inputs, on a cycle with no load.
- *stay-idle*: `ST_IDLE` stays in `ST_IDLE` on a cycle with no load.

Top module: `sram_pipe_burst`

## Requirements
- R1: While `rst_n` is low, `dq_drive_o` is 0 and the device is deselected.
- R2: A read registered on edge N is not yet driven after edge N when the device was idle. After edge N+1 the stored word appears on `dq_o` and `dq_drive_o` is 1, provided `out_en_n_i` is 0.
- R3: `dq_drive_o` follows `out_en_n_i` without waiting for a clock. Setting it to 1 stops the drive at once, and setting it back to 0 restores the same word.
- R4: A selected controller load with `wr_all_n_i` = 0 writes every lane from `din_i`, whatever the lane enables are. A write cycle never drives the outputs.
- R5: With `wr_all_n_i` = 1 and `lane_wr_gate_n_i` = 0, lane i (bits [9i+8:9i]) is written only when `lane_wr_n_i[i]` = 0, and the other lane keeps its contents.
- R6: With `wr_all_n_i` = 1 and either `lane_wr_gate_n_i` = 1 or both lane enables high, the cycle is a read and memory is unchanged.
- R7: A cycle started by `ld_cpu_n_i` is a read even if write controls are active. A write on the next cycle without a load stores to the burst address.
- R8: With `order_i` = 0, the low two address bits of a burst run (start + k) mod 4 for the k-th word.
- R9: With `order_i` = 1, the low two address bits run start XOR k.
- R10: The counter steps only on cycles with `step_n_i` = 0 and both strobes high. Otherwise the current burst address repeats.
- R11: `ld_cpu_n_i` is ignored while `sel_n_i` = 1, so the running burst continues at its current address. `ld_ctl_n_i` is always honoured.
- R12: A load with any chip select inactive (`sel_n_i` = 1, `sel_hi_i` = 0 or `sel_lo_n_i` = 1) turns `dq_drive_o` off after the following edge. Steps stay ignored while deselected.
- R13: After four steps the burst counter wraps and the burst returns to its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W | Word address, taken on a load |
| din_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data, high impedance when not driven |
| dq_drive_o | output | 1 | High while `dq_o` is driven |
| sel_n_i | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_hi_i | input | 1 | Depth chip select, active high |
| sel_lo_n_i | input | 1 | Depth chip select, active low |
| ld_cpu_n_i | input | 1 | Processor load strobe, active low |
| ld_ctl_n_i | input | 1 | Controller load strobe, active low |
| step_n_i | input | 1 | Burst step, active low |
| lane_wr_n_i | input | LANES | Per-lane write enables, active low |
| lane_wr_gate_n_i | input | 1 | Master enable for the lane enables, active low |
| wr_all_n_i | input | 1 | Write-all-lanes, active low, overrides the lane enables |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |

## Verification
Every result is due a fixed number of edges after its stimulus. A read or deselect placed on edge N shows on the outputs after edge N+1, and a write placed on edge N is visible to a read registered on edge N+1 or later. The output enable acts within the same cycle. Each scenario drives inputs on the falling edge and steps whole cycles. It samples only on the falling edge after the edge where a result is due, and for bursts this gives one sample per step with the counter value lagging one edge. The checker properties use the same two-edge distance from a load to the output drive.

// File: rtl/sram_pipe_pkg.sv
`timescale 1ns/1ps
package sram_pipe_pkg;

    // Cycle type held in the input stage register.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;

    // Width of the internal burst counter (fixed by the burst length of four).
    localparam int BURST_W = 2;

endpackage

// File: rtl/sram_burst_seq.sv
`timescale 1ns/1ps
// Burst address generator: holds the start offset and a step counter,
// and maps them to the low address bits in linear or interleaved order.
module sram_burst_seq #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [BW-1:0] start_i,
    input  logic          order_i,
    output logic [BW-1:0] low_o
);

    logic [BW-1:0] start_q;
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            start_q <= start_i;
            cnt_q   <= '0;
        end else if (adv_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Order select is not registered: it changes the mapping at once.
    always_comb begin
        if (order_i)
            low_o = start_q ^ cnt_q;
        else
            low_o = start_q + cnt_q;
    end

endmodule

// File: rtl/sram_wr_decode.sv
`timescale 1ns/1ps
// Turns the write controls into a lane mask; an all-zero mask means read.
module sram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n_i,
    input  logic             gate_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    output logic [LANES-1:0] mask_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (!wr_all_n_i)
                mask_o[g] = 1'b1;
            else if (!gate_n_i)
                mask_o[g] = !lane_wr_n_i[g];
            else
                mask_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
// Storage split in byte lanes, with a registered read port per lane.
module sram_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  wr_mask_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_mask_i[g])
                mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q <= '0;
            else if (rd_en_i)
                rd_q <= mem_q[addr_i];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sram_pipe_burst.sv
`timescale 1ns/1ps
// Pipelined burst SRAM: input stage registers, cycle-type sequencer,
// burst counter, lane array with registered read, async output gate.
module sram_pipe_burst
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_drive_o,
    input  logic              sel_n_i,
    input  logic              sel_hi_i,
    input  logic              sel_lo_n_i,
    input  logic              ld_cpu_n_i,
    input  logic              ld_ctl_n_i,
    input  logic              step_n_i,
    input  logic [LANES-1:0]  lane_wr_n_i,
    input  logic              lane_wr_gate_n_i,
    input  logic              wr_all_n_i,
    input  logic              out_en_n_i,
    input  logic              order_i
);

    localparam int HI_W = ADDR_W - BURST_W;

    cyc_state_e         state_q, state_d;
    logic [LANES-1:0]   lane_mask;
    logic [LANES-1:0]   mask_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] low_addr;
    logic [DATA_W-1:0]  rdata;
    logic               out_valid_q;

    // Input decode of the current edge.
    logic sel_now, cpu_load, ctl_load, load_any, start_rd, wr_any, step_ok;

    assign sel_now  = !sel_n_i && sel_hi_i && !sel_lo_n_i;
    assign cpu_load = !ld_cpu_n_i && !sel_n_i;
    assign ctl_load = !ld_ctl_n_i;
    assign load_any = cpu_load || ctl_load;
    assign wr_any   = |lane_mask;
    assign start_rd = cpu_load || !wr_any;
    assign step_ok  = !step_n_i && ld_cpu_n_i && ld_ctl_n_i;

    sram_wr_decode #(.LANES(LANES)) u_wr_dec (
        .wr_all_n_i  (wr_all_n_i),
        .gate_n_i    (lane_wr_gate_n_i),
        .lane_wr_n_i (lane_wr_n_i),
        .mask_o      (lane_mask)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_any)
                    state_d = !sel_now ? ST_IDLE : (start_rd ? ST_READ : ST_WRITE);
            end
            ST_READ, ST_WRITE: begin
                if (load_any)
                    state_d = !sel_now ? ST_IDLE : (start_rd ? ST_READ : ST_WRITE);
                else
                    state_d = wr_any ? ST_WRITE : ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Input stage: address high bits, write data and lane mask.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            wdata_q <= '0;
            hi_q    <= '0;
        end else begin
            mask_q  <= (state_d == ST_WRITE) ? lane_mask : '0;
            wdata_q <= din_i;
            if (load_any && sel_now)
                hi_q <= addr_i[ADDR_W-1:BURST_W];
        end
    end

    sram_burst_seq #(.BW(BURST_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_any && sel_now),
        .adv_i   (step_ok && (state_q != ST_IDLE)),
        .start_i (addr_i[BURST_W-1:0]),
        .order_i (order_i),
        .low_o   (low_addr)
    );

    sram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    ({hi_q, low_addr}),
        .wr_mask_i ((state_q == ST_WRITE) ? mask_q : '0),
        .rd_en_i   (state_q == ST_READ),
        .wdata_i   (wdata_q),
        .rdata_o   (rdata)
    );

    // Output process: drive is valid one edge after a read cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_valid_q <= 1'b0;
        else
            out_valid_q <= (state_q == ST_READ);
    end

    assign dq_drive_o = out_valid_q && !out_en_n_i;
    assign dq_o       = dq_drive_o ? rdata : 'z;

endmodule

// File: rtl/sram_pipe_burst_chk.sv
`timescale 1ns/1ps
module sram_pipe_burst_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n_i,
    input logic sel_hi_i,
    input logic sel_lo_n_i,
    input logic ld_cpu_n_i,
    input logic ld_ctl_n_i,
    input logic wr_all_n_i,
    input logic lane_wr_gate_n_i,
    input logic out_en_n_i,
    input logic dq_drive_o
);

    logic sel, honoured;
    assign sel      = !sel_n_i && sel_hi_i && !sel_lo_n_i;
    assign honoured = !ld_ctl_n_i || (!ld_cpu_n_i && !sel_n_i);

    // R1: no drive while in reset
    always @(negedge clk) begin
        if (!rst_n)
            p_reset_quiet_r1: assert (!dq_drive_o);
    end

    // R12: unselected load turns the outputs off after the following edge
    p_desel_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (honoured && !sel) |-> ##2 !dq_drive_o);

    // R4: a write-all controller load never drives the outputs
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ctl_n_i && ld_cpu_n_i && sel && !wr_all_n_i) |-> ##2 !dq_drive_o);

    // R2: a selected read load drives two edges later under the output enable
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ctl_n_i && ld_cpu_n_i && sel && wr_all_n_i && lane_wr_gate_n_i)
        |-> ##2 (dq_drive_o == !out_en_n_i));

    // R7: a processor load is always a read
    p_cpu_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cpu_n_i && sel) |-> ##2 (dq_drive_o == !out_en_n_i));

endmodule

bind sram_pipe_burst sram_pipe_burst_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .sel_n_i          (sel_n_i),
    .sel_hi_i         (sel_hi_i),
    .sel_lo_n_i       (sel_lo_n_i),
    .ld_cpu_n_i       (ld_cpu_n_i),
    .ld_ctl_n_i       (ld_ctl_n_i),
    .wr_all_n_i       (wr_all_n_i),
    .lane_wr_gate_n_i (lane_wr_gate_n_i),
    .out_en_n_i       (out_en_n_i),
    .dq_drive_o       (dq_drive_o)
);

// File: tb/sram_pipe_burst_tb_top.sv
`timescale 1ns/1ps
module sram_pipe_burst_tb_top;

    localparam int AW = 8;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = LW * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dq;
    logic          drive;
    logic          sel_n, sel_hi, sel_lo_n;
    logic          ld_cpu_n, ld_ctl_n, step_n;
    logic [NL-1:0] lane_wr_n;
    logic          gate_n, wr_all_n, oe_n, order;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [DW-1:0] ref_mem [1 << AW];

    always #2 clk = ~clk;

    sram_pipe_burst #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut_i (
        .clk (clk), .rst_n (rst_n), .addr_i (addr), .din_i (din),
        .dq_o (dq), .dq_drive_o (drive),
        .sel_n_i (sel_n), .sel_hi_i (sel_hi), .sel_lo_n_i (sel_lo_n),
        .ld_cpu_n_i (ld_cpu_n), .ld_ctl_n_i (ld_ctl_n), .step_n_i (step_n),
        .lane_wr_n_i (lane_wr_n), .lane_wr_gate_n_i (gate_n),
        .wr_all_n_i (wr_all_n), .out_en_n_i (oe_n), .order_i (order)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in;
        sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; step_n = 1'b1;
        lane_wr_n = '1; gate_n = 1'b1; wr_all_n = 1'b1; oe_n = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic gw, input logic gt, input logic [NL-1:0] ln);
        ld_ctl_n = 1'b0; addr = a; din = d;
        wr_all_n = gw; gate_n = gt; lane_wr_n = ln;
        tick;
        idle_in;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic dv);
        ld_ctl_n = 1'b0; addr = a;
        tick;
        idle_in;
        tick;
        v = dq; dv = drive;
    endtask

    task automatic deselect;
        ld_ctl_n = 1'b0; sel_n = 1'b1;
        tick;
        idle_in;
        tick;
        tick;
    endtask

    task automatic t_reset;
        idle_in; order = 1'b0; addr = '0; din = '0;
        rst_n = 1'b0;
        repeat (3) tick;
        chk(drive == 1'b0, "R1 drive in reset", {17'd0, drive}, '0);
        rst_n = 1'b1;
        tick;
        chk(drive == 1'b0, "R1 idle after reset", {17'd0, drive}, '0);
    endtask

    task automatic t_read_latency;
        logic [DW-1:0] v; logic dv;
        wr(8'h10, 18'h2A5A5, 1'b0, 1'b1, 2'b11); ref_mem[8'h10] = 18'h2A5A5;
        deselect;
        ld_ctl_n = 1'b0; addr = 8'h10;
        tick;
        idle_in;
        chk(drive == 1'b0, "R2 not driven after load edge", {17'd0, drive}, '0);
        tick;
        v = dq; dv = drive;
        chk(dv && v == ref_mem[8'h10], "R2 data after next edge", v, ref_mem[8'h10]);
    endtask

    task automatic t_oe_async;
        logic [DW-1:0] v; logic dv;
        rd(8'h10, v, dv);
        oe_n = 1'b1; #1;
        chk(drive == 1'b0, "R3 oe high stops drive", {17'd0, drive}, '0);
        oe_n = 1'b0; #0.5;
        chk(drive && dq == ref_mem[8'h10], "R3 oe low restores", dq, ref_mem[8'h10]);
    endtask

    task automatic t_global_write;
        logic [DW-1:0] v; logic dv;
        for (int i = 0; i < 4; i++) begin
            logic [DW-1:0] d;
            d = 18'h01234 + 18'(i) * 18'h0F0F1;
            wr(8'h20 + 8'(i), d, 1'b0, 1'b1, 2'b11);
            ref_mem[8'h20 + i] = d;
        end
        // write-all overrides a partial lane selection
        wr(8'h23, 18'h3C3C3, 1'b0, 1'b0, 2'b10); ref_mem[8'h23] = 18'h3C3C3;
        for (int i = 0; i < 4; i++) begin
            rd(8'h20 + 8'(i), v, dv);
            chk(dv && v == ref_mem[8'h20 + i], "R4 global write readback", v, ref_mem[8'h20 + i]);
        end
    endtask

    task automatic t_byte_write;
        logic [DW-1:0] v; logic dv;
        wr(8'h30, 18'h3FFFF, 1'b0, 1'b1, 2'b11); ref_mem[8'h30] = 18'h3FFFF;
        wr(8'h30, 18'h00155, 1'b1, 1'b0, 2'b10);
        ref_mem[8'h30] = {ref_mem[8'h30][17:9], 9'h155};
        rd(8'h30, v, dv);
        chk(dv && v == ref_mem[8'h30], "R5 lane0 only", v, ref_mem[8'h30]);
        wr(8'h30, 18'h15400, 1'b1, 1'b0, 2'b01);
        ref_mem[8'h30] = {9'h0AA, ref_mem[8'h30][8:0]};
        rd(8'h30, v, dv);
        chk(dv && v == ref_mem[8'h30], "R5 lane1 only", v, ref_mem[8'h30]);
    endtask

    task automatic t_no_write;
        logic [DW-1:0] v; logic dv;
        wr(8'h30, 18'h00000, 1'b1, 1'b1, 2'b00);
        rd(8'h30, v, dv);
        chk(dv && v == ref_mem[8'h30], "R6 gate off no write", v, ref_mem[8'h30]);
        wr(8'h30, 18'h00000, 1'b1, 1'b0, 2'b11);
        rd(8'h30, v, dv);
        chk(dv && v == ref_mem[8'h30], "R6 lanes off no write", v, ref_mem[8'h30]);
    endtask

    task automatic t_cpu_read_first;
        logic [DW-1:0] v; logic dv;
        wr(8'h50, 18'h11111, 1'b0, 1'b1, 2'b11); ref_mem[8'h50] = 18'h11111;
        ld_cpu_n = 1'b0; addr = 8'h50; din = 18'h22222; wr_all_n = 1'b0;
        tick;
        ld_cpu_n = 1'b1; din = 18'h33333; wr_all_n = 1'b0;
        tick;
        v = dq; dv = drive;
        chk(dv && v == 18'h11111, "R7 cpu load reads old word", v, 18'h11111);
        idle_in;
        tick;
        ref_mem[8'h50] = 18'h33333;
        rd(8'h50, v, dv);
        chk(dv && v == 18'h33333, "R7 follow-on write stored", v, 18'h33333);
    endtask

    function automatic logic [1:0] bseq(input logic md, input logic [1:0] s, input int k);
        return md ? (s ^ 2'(k)) : (s + 2'(k));
    endfunction

    task automatic t_burst(input logic md, input logic [AW-1:0] sa, input string tag);
        for (int i = 0; i < 4; i++) begin
            logic [DW-1:0] d;
            d = 18'h10000 + 18'(i) * 18'h00111 + (md ? 18'h08000 : 18'h0);
            wr(8'h40 + 8'(i), d, 1'b0, 1'b1, 2'b11);
            ref_mem[8'h40 + i] = d;
        end
        order = md;
        ld_ctl_n = 1'b0; addr = sa;
        tick;
        idle_in; step_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            logic [AW-1:0] ea;
            tick;
            ea = {sa[AW-1:2], bseq(md, sa[1:0], k % 4)};
            // R13: k = 4 revisits the start after the wrap
            chk(drive && dq == ref_mem[ea], tag, dq, ref_mem[ea]);
        end
        idle_in; order = 1'b0;
    endtask

    task automatic t_suspend;
        logic [DW-1:0] exp [4];
        ld_ctl_n = 1'b0; addr = 8'h40;
        tick;
        idle_in;
        exp[0] = ref_mem[8'h40]; exp[1] = ref_mem[8'h40];
        exp[2] = ref_mem[8'h40]; exp[3] = ref_mem[8'h41];
        for (int k = 0; k < 4; k++) begin
            tick;
            chk(drive && dq == exp[k], "R10 step only when requested", dq, exp[k]);
            step_n = (k >= 1) ? 1'b0 : 1'b1;
        end
        // strobe together with step loads and does not advance
        ld_ctl_n = 1'b0; step_n = 1'b0; addr = 8'h42;
        tick;
        idle_in;
        tick;
        chk(drive && dq == ref_mem[8'h42], "R10 load beats step", dq, ref_mem[8'h42]);
    endtask

    task automatic t_cpu_ignored;
        ld_ctl_n = 1'b0; addr = 8'h41;
        tick;
        ld_ctl_n = 1'b1; ld_cpu_n = 1'b0; sel_n = 1'b1; addr = 8'h10;
        tick;
        idle_in;
        tick;
        chk(drive && dq == ref_mem[8'h41], "R11 cpu strobe ignored", dq, ref_mem[8'h41]);
        ld_cpu_n = 1'b0; addr = 8'h10;
        tick;
        idle_in;
        tick;
        chk(drive && dq == ref_mem[8'h10], "R11 cpu strobe honoured", dq, ref_mem[8'h10]);
    endtask

    task automatic t_deselect;
        for (int e = 0; e < 3; e++) begin
            ld_ctl_n = 1'b0; addr = 8'h43;
            tick;
            ld_ctl_n = 1'b0;
            if (e == 0) sel_n = 1'b1;
            if (e == 1) sel_hi = 1'b0;
            if (e == 2) sel_lo_n = 1'b1;
            tick;
            idle_in;
            chk(drive && dq == ref_mem[8'h43], "R12 still driven one edge", dq, ref_mem[8'h43]);
            tick;
            chk(drive == 1'b0, "R12 off after deselect", {17'd0, drive}, '0);
            step_n = 1'b0;
            tick;
            tick;
            idle_in;
            chk(drive == 1'b0, "R12 step ignored when idle", {17'd0, drive}, '0);
        end
    endtask

    initial begin
        t_reset;
        t_read_latency;
        t_oe_async;
        t_global_write;
        t_byte_write;
        t_no_write;
        t_cpu_read_first;
        t_burst(1'b0, 8'h42, "R8 linear order R13 wrap");
        t_burst(1'b1, 8'h41, "R9 interleaved order R13 wrap");
        t_suspend;
        t_cpu_ignored;
        t_deselect;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule